// File: doc/BRIEF.md
# Twin-Copy Configuration Word with Toggle-Triggered Commit

This block holds the 16-bit word that configures a filter datapath. It keeps two copies. A staging copy takes every host write. A live copy drives the datapath. The host can stage a new configuration while the datapath keeps running on the old one. To commit the staged word, the host inverts the level of a single commit wire. A rising change and a falling change work the same way, so each commit only has to flip the wire once.

After reset the block is unloaded. The first accepted write fills both copies, so the datapath has a valid configuration without any commit. From then on, writes change only the staging copy until the next reset. The four lowest bits are reserved and must be zero. A write that sets any of them is still stored, but it raises a sticky error flag, and those bits read as zero in the live copy. The block decodes the live word into three one-hot arrangement outputs: single filter, two independent filters, or two filters in cascade. In the two-filter arrangements both networks share this one live word.

Host writes use a valid/ready handshake. Ready is low during reset. From the first clock edge after reset it stays high, so the block never applies back-pressure, and a write is accepted on any edge where valid and ready are both high. The commit wire and all outputs are plain level signals.

Top module: `cfg_twin_reg`

## Requirements
- R1: While reset is held, `wr_ready` is 0. After release, `live_word` is 0x0000, `rsvd_err` is 0, and the decode shows two independent filters.
- R2: Once the live copy has been loaded, an accepted write changes only the staging copy. `live_word` keeps its value until a commit.
- R3: Any change of `commit_tgl`, rising or falling, copies the staging word into the live copy. `commit_tgl` is sampled on clock edge k, and `live_word` shows the new word after edge k+1. `commit_tgl` must be low while reset is held.
- R4: The first write accepted after reset loads the live copy directly, visible after its accepting edge. This direct load takes priority over a commit detected on the same edge.
- R5: The decode of the live word works as follows. If bit 15 is 1, `mode_single` is 1 whatever bit 4 holds. If bit 15 is 0 and bit 4 is 0, `mode_dual_indep` is 1. If bit 15 is 0 and bit 4 is 1, `mode_dual_cascade` is 1. Exactly one of the three is high at any time.
- R6: Bits 3:0 of `live_word` are always 0, even when the word written had ones there.
- R7: An accepted write with any of bits 3:0 set raises `rsvd_err` after the accepting edge. The flag stays set through later clean writes and clears only on reset.
- R8: Suppose a write is accepted on the same edge that acts on a detected commit. The live copy then takes the staging word from before that write, and the new write waits for the next commit.
- R9: `wr_ready` is 1 on every cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Block accepts writes (always 1 once out of reset) |
| wr_data | input | 16 | Configuration word to stage |
| commit_tgl | input | 1 | Commit wire; each level change commits the staged word |
| live_word | output | 16 | Live configuration word |
| mode_single | output | 1 | Single-filter arrangement |
| mode_dual_indep | output | 1 | Two independent filters |
| mode_dual_cascade | output | 1 | Two filters in cascade |
| rsvd_err | output | 1 | Sticky flag: a write set reserved bits |

## Verification
The bench commits on both a rising and a falling change of the commit wire. A design that reacted to only one direction would leave the live word stale on alternate commits. It lines up a write with the edge that acts on a commit. A design that passed the fresh write through would show the new word one commit too early. It also lines up a first-after-reset write with a pending commit. A design that let the commit win would show zero instead of the written word. Held-write windows, a word with bit 15 and bit 4 both set, and a write with reserved bits followed by a clean write cover the following faults: a shadow that leaks into the live copy, a decode that looks at bit 4 in single mode, and an error flag that is not sticky.

// File: rtl/cfg_twin_pkg.sv
package cfg_twin_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned RSVD_W   = 4;
  localparam int unsigned MODE_BIT = 15;
  localparam int unsigned ARR_BIT  = 4;

  typedef enum logic [1:0] {
    ARR_DUAL_INDEP = 2'd0,
    ARR_DUAL_CASC  = 2'd1,
    ARR_SINGLE     = 2'd2
  } arrangement_e;
endpackage

// File: rtl/cfg_swap_edge.sv
module cfg_swap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic tog_o
);
  logic seen_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      seen_q <= level_i;
      prev_q <= seen_q;
    end
  end

  assign tog_o = seen_q ^ prev_q;

  AST_EDGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i != seen_q) |=> tog_o); // R3
endmodule

// File: rtl/cfg_twin_store.sv
module cfg_twin_store #(
  parameter int unsigned W      = cfg_twin_pkg::WORD_W,
  parameter int unsigned RSVD_W = cfg_twin_pkg::RSVD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  output logic [W-1:0] live_o,
  output logic         err_o
);
  localparam logic [W-1:0] KEEP_MASK = {{(W-RSVD_W){1'b1}}, {RSVD_W{1'b0}}};

  logic [W-1:0] stage_q;
  logic [W-1:0] live_q;
  logic         loaded_q;
  logic         err_q;
  logic         dirty_rsvd;

  assign dirty_rsvd = |wr_data[RSVD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= '0;
      live_q   <= '0;
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wr_fire) begin
        stage_q <= wr_data;
        if (dirty_rsvd) err_q <= 1'b1;
      end
      if (wr_fire && !loaded_q) begin
        live_q   <= wr_data & KEEP_MASK;
        loaded_q <= 1'b1;
      end else if (commit && loaded_q) begin
        live_q <= stage_q & KEEP_MASK;
      end
    end
  end

  assign live_o = live_q;
  assign err_o  = err_q;

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !commit) |=> $stable(live_q)); // R2
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && commit) |=> (live_q == ($past(stage_q) & KEEP_MASK))); // R8
  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[RSVD_W-1:0] == '0); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R7
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !loaded_q) |=> (live_q == ($past(wr_data) & KEEP_MASK))); // R4
endmodule

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_twin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic single_bit,
  input  logic arr_bit,
  output logic single_o,
  output logic indep_o,
  output logic cascade_o
);
  arrangement_e arr;

  always_comb begin
    if (single_bit)   arr = ARR_SINGLE;
    else if (arr_bit) arr = ARR_DUAL_CASC;
    else              arr = ARR_DUAL_INDEP;
  end

  assign single_o  = (arr == ARR_SINGLE);
  assign indep_o   = (arr == ARR_DUAL_INDEP);
  assign cascade_o = (arr == ARR_DUAL_CASC);

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({single_o, indep_o, cascade_o})); // R5
endmodule

// File: rtl/cfg_twin_reg.sv
module cfg_twin_reg
  import cfg_twin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              commit_tgl,
  output logic [WORD_W-1:0] live_word,
  output logic              mode_single,
  output logic              mode_dual_indep,
  output logic              mode_dual_cascade,
  output logic              rsvd_err
);
  logic ready_q;
  logic commit;
  logic wr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready = ready_q;
  assign wr_fire  = wr_valid && ready_q;

  cfg_swap_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (commit_tgl),
    .tog_o   (commit)
  );

  cfg_twin_store #(.W(WORD_W), .RSVD_W(RSVD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_data (wr_data),
    .commit  (commit),
    .live_o  (live_word),
    .err_o   (rsvd_err)
  );

  cfg_mode_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_bit (live_word[MODE_BIT]),
    .arr_bit    (live_word[ARR_BIT]),
    .single_o   (mode_single),
    .indep_o    (mode_dual_indep),
    .cascade_o  (mode_dual_cascade)
  );

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> wr_ready); // R9
endmodule

// File: tb/cfg_twin_reg_tb.sv
module cfg_twin_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic        commit_tgl = 1'b0;
  logic [15:0] live_word;
  logic        mode_single, mode_dual_indep, mode_dual_cascade, rsvd_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [15:0] act;
    logic        err;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_stage, m_live;
  bit          m_loaded;
  logic        m_err;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_twin_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .commit_tgl(commit_tgl), .live_word(live_word),
    .mode_single(mode_single), .mode_dual_indep(mode_dual_indep),
    .mode_dual_cascade(mode_dual_cascade), .rsvd_err(rsvd_err)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected items when due and compares all outputs
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " live_word"}, live_word, e.act);
      chk({e.tag, " mode_single (R5)"}, {15'd0, mode_single}, {15'd0, e.act[15]});
      chk({e.tag, " mode_dual_indep (R5)"}, {15'd0, mode_dual_indep},
          {15'd0, !e.act[15] && !e.act[4]});
      chk({e.tag, " mode_dual_cascade (R5)"}, {15'd0, mode_dual_cascade},
          {15'd0, !e.act[15] && e.act[4]});
      chk({e.tag, " rsvd_err (R7)"}, {15'd0, rsvd_err}, {15'd0, e.err});
    end
  end

  task automatic push(int due, string tag);
    exp_t e;
    e.due = due; e.act = m_live; e.err = m_err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_write(logic [15:0] d);
    if (!m_loaded) begin
      m_live = d & 16'hFFF0;
      m_loaded = 1;
    end
    m_stage = d;
    if (d[3:0] != 4'h0) m_err = 1'b1;
  endtask

  // all driver tasks start and end at a negedge
  task automatic do_write(logic [15:0] d, string tag);
    wr_valid = 1'b1; wr_data = d;
    model_write(d);
    push(cyc + 1, tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_commit(string tag);
    commit_tgl = ~commit_tgl;
    push(cyc + 1, {tag, " pre-commit hold"});
    m_live = m_stage & 16'hFFF0;
    push(cyc + 2, tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  // commit change, then a write accepted on the edge that acts on it
  task automatic commit_with_write(logic [15:0] d, string tag);
    commit_tgl = ~commit_tgl;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    if (m_loaded) m_live = m_stage & 16'hFFF0;
    model_write(d);
    push(cyc + 1, tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      push(cyc + 1, tag);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 wr_ready low in reset", {15'd0, wr_ready}, 16'd0);
    m_stage = '0; m_live = '0; m_loaded = 0; m_err = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 wr_ready high", {15'd0, wr_ready}, 16'd1);
    push(cyc, "R1 reset state");
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    do_write(16'h8000, "R4 first write direct");
    do_write(16'h0010, "R2 shadow write");
    idle(3, "R2 live held");
    do_commit("R3 rising commit cascade");
    do_write(16'h0000, "R2 shadow write 2");
    do_commit("R3 falling commit indep");
    do_write(16'h8010, "R2 shadow write 3");
    do_commit("R5 single ignores bit4");
    do_write(16'h004F, "R7 reserved write err");
    do_commit("R6 reserved cleared");
    do_write(16'h0010, "R7 err sticky");
    idle(2, "R7 err sticky hold");
    commit_with_write(16'h8000, "R8 commit takes old stage");
    idle(2, "R8 hold");
    do_commit("R8 later commit");
    commit_tgl = 1'b0;
    idle(3, "settle");
    do_reset();
    chk("R7 err cleared by reset", {15'd0, rsvd_err}, 16'd0);
    commit_with_write(16'h0010, "R4 first write beats commit");
    idle(3, "R4 hold");
    chk("R9 wr_ready stays high", {15'd0, wr_ready}, 16'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule